// File: doc/BRIEF.md
# Interpolated Gaussian Log-Sum Unit

This unit evaluates the function sb(z) = log2(1 + 2^z) for non-positive fixed-point arguments. That function is the correction term a logarithmic-number-system adder needs after forming the difference of two log-domain operands. The answer is built from a coarse table of the function at evenly spaced points. The two table points that bracket the argument are read in the same cycle through two read ports of one table. Their difference forms the local slope, the slope is scaled by the discarded low bits of the argument, and the product is subtracted from the upper point.

The table is filled at elaboration by an integer-only constant function, so the unit needs no memory image. With the default precision of F = 12 output fraction bits, the grid spacing is 2^-4 over the magnitude range 0 to 12, which gives 193 entries. Arguments beyond that range return zero without any table access. Non-negative arguments return exactly 1.0. A new argument is accepted on every cycle, and each result appears three cycles after its argument.

Top module: `lns_sb_unit`

## Requirements
- R1: `in_z` is a 20-bit two's-complement value with 12 fraction bits. `out_sb` is unsigned with 12 fraction bits. For -12.0 <= z < 0, `out_sb` lies within 1 ulp (2^-12) of the real value log2(1 + 2^z) and never exceeds 4096.
- R2: `out_valid` is high exactly three clock cycles after a cycle in which `in_valid` was high, and is low otherwise.
- R3: Any argument z >= 0 (sign bit of `in_z` clear) yields `out_sb` = 4096 (1.0) exactly.
- R4: Any argument z < -12.0 (magnitude above 49152 counts) yields `out_sb` = 0, including the most negative code -524288.
- R5: The boundary argument z = -12.0 (code -49152) still uses the table and yields a non-zero result within 1 ulp of the real value.
- R6: Over the range -12.0 <= z <= 0, the output is non-increasing as the argument decreases by one code.
- R7: During reset and on the first cycle after it, `out_valid` is low and `out_sb` is zero.
- R8: Arguments presented on consecutive cycles each produce their own result in order, with no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_z` in this cycle |
| in_z | input | 20 | Argument z, two's complement, 12 fraction bits |
| out_valid | output | 1 | Qualifies `out_sb`; follows `in_valid` by three cycles |
| out_sb | output | 13 | sb(z), unsigned, 12 fraction bits |

## Verification
On every cycle, the bound checker compares the valid pipeline against its own three-deep record of `in_valid`. It also confirms that non-negative arguments give exactly 1.0, that over-range arguments give zero, that in-range results are non-zero and bounded by 1.0, and that reset clears the output. The accuracy within one ulp of the real function and the monotone descent across adjacent codes depend on the table contents and on the rounding, and only the bench's exhaustive sweep of every in-range code against a real-valued model can show them. The same applies to the ordering of results under back-to-back and gapped traffic.

// File: rtl/lns_sb_pkg.sv
package lns_sb_pkg;

   // Integer square root of a 64-bit value, bit by bit from the top.
   function automatic logic [31:0] isqrt64(input logic [63:0] v);
      logic [31:0] root;
      logic [31:0] trial;
      root = '0;
      for (int b = 31; b >= 0; b--) begin
         trial = root | (32'd1 << b);
         if (({32'd0, trial} * {32'd0, trial}) <= v) root = trial;
      end
      return root;
   endfunction

   // sb at grid point k (spacing 2^-n) scaled by 2^frac, rounded to nearest.
   // Integer arithmetic only: 2^-k/2^n from chained square roots of 0.5,
   // then log2 of (1+u) by repeated squaring.
   function automatic int unsigned sb_point(input int unsigned k,
                                            input int unsigned n,
                                            input int unsigned frac);
      logic [63:0]  u;
      logic [63:0]  r;
      logic [63:0]  v;
      int unsigned  bits;
      int unsigned  whole;
      u = 64'h1_0000_0000;          // 1.0 in Q32
      r = 64'h0_8000_0000;          // 0.5 in Q32
      for (int b = int'(n) - 1; b >= 0; b--) begin
         r = {32'd0, isqrt64(r << 32)};
         if (k[b]) u = (u * r) >> 32;
      end
      u = u >> (k >> n);
      v = (64'h1_0000_0000 + u) >> 2;   // 1+u in Q30
      whole = 0;
      if (v >= 64'h8000_0000) begin
         whole = 1;
         v = v >> 1;
      end
      bits = 0;
      for (int i = 0; i < int'(frac) + 4; i++) begin
         v = (v * v) >> 30;
         bits = bits << 1;
         if (v >= 64'h8000_0000) begin
            bits = bits | 1;
            v = v >> 1;
         end
      end
      bits = bits + (whole << (frac + 4));
      return (bits + 8) >> 4;
   endfunction

endpackage

// File: rtl/lns_sb_decode.sv
module lns_sb_decode #(
   parameter int Z_W    = 20,
   parameter int Z_FRAC = 12,
   parameter int N      = 4,
   parameter int RANGE  = 12,
   parameter int E      = 193,
   parameter int AW     = 8
) (
   input  logic [Z_W-1:0]          z,
   output logic [AW-1:0]           idx,
   output logic [AW-1:0]           idx_next,
   output logic [Z_FRAC-N-1:0]     zl,
   output logic                    over
);
   localparam int ZL_W = Z_FRAC - N;
   localparam logic [Z_W-1:0] LIMIT = Z_W'(RANGE) << Z_FRAC;

   logic [Z_W-1:0] mag;

   always_comb begin
      // positive arguments fold onto z = 0
      mag      = z[Z_W-1] ? (~z + 1'b1) : '0;
      over     = (mag > LIMIT);
      idx      = over ? '0 : AW'(mag >> ZL_W);
      idx_next = (idx == AW'(E - 1)) ? idx : idx + 1'b1;
      zl       = over ? '0 : mag[ZL_W-1:0];
   end

endmodule

// File: rtl/lns_sb_rom.sv
module lns_sb_rom #(
   parameter int E     = 193,
   parameter int AW    = 8,
   parameter int TW    = 15,
   parameter int N     = 4,
   parameter int TFRAC = 14
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  en,
   input  logic [1:0][AW-1:0]    addr,
   output logic [1:0][TW-1:0]    data
);
   import lns_sb_pkg::*;

   typedef logic [E-1:0][TW-1:0] table_t;

   function automatic table_t build_table();
      table_t t;
      for (int k = 0; k < E; k++) t[k] = TW'(sb_point(k, N, TFRAC));
      return t;
   endfunction

   localparam table_t TABLE = build_table();

   for (genvar p = 0; p < 2; p++) begin : g_port
      always_ff @(posedge clk) begin
         if (rst)     data[p] <= '0;
         else if (en) data[p] <= (int'(addr[p]) < E) ? TABLE[addr[p]] : '0;
      end
   end

endmodule

// File: rtl/lns_sb_interp.sv
module lns_sb_interp #(
   parameter int TW   = 15,
   parameter int ZL_W = 8,
   parameter int G    = 2,
   parameter int F    = 12
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            vld_i,
   input  logic            over_i,
   input  logic [TW-1:0]   base_i,
   input  logic [TW-1:0]   next_i,
   input  logic [ZL_W-1:0] zl_i,
   output logic            vld_o,
   output logic [F:0]      sb_o
);
   localparam int PW = TW + ZL_W;
   localparam int SH = ZL_W + G;

   logic [TW-1:0] diff;
   logic [PW-1:0] prod;
   logic [TW-1:0] base_q;
   logic [PW-1:0] prod_q;
   logic          over_q;
   logic          vld_q;
   logic [PW-1:0] acc;
   logic [PW-1:0] rounded;

   // the table falls with magnitude, so base >= next
   always_comb begin
      diff = base_i - next_i;
      prod = {{ZL_W{1'b0}}, diff} * {{TW{1'b0}}, zl_i};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         prod_q <= '0;
         over_q <= 1'b0;
         vld_q  <= 1'b0;
      end else begin
         base_q <= base_i;
         prod_q <= prod;
         over_q <= over_i;
         vld_q  <= vld_i;
      end
   end

   always_comb begin
      acc     = {base_q, {ZL_W{1'b0}}} - prod_q;
      rounded = acc + (PW'(1) << (SH - 1));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sb_o  <= '0;
         vld_o <= 1'b0;
      end else begin
         sb_o  <= over_q ? '0 : (F+1)'(rounded >> SH);
         vld_o <= vld_q;
      end
   end

endmodule

// File: rtl/lns_sb_unit.sv
module lns_sb_unit #(
   parameter int Z_W    = 20,
   parameter int Z_FRAC = 12,
   parameter int F      = 12,
   parameter int RANGE  = 12,
   parameter int GUARD  = 2
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           in_valid,
   input  logic [Z_W-1:0] in_z,
   output logic           out_valid,
   output logic [F:0]     out_sb
);
   localparam int N    = (F - 4) / 2;
   localparam int ZL_W = Z_FRAC - N;
   localparam int E    = RANGE * (2 ** N) + 1;
   localparam int AW   = $clog2(E);
   localparam int TW   = F + GUARD + 1;

   if (N < 1) begin : g_bad_prec
      $error("precision F too small for a grid");
   end
   if (ZL_W < 1) begin : g_bad_frac
      $error("input needs more fraction bits than the grid");
   end
   if (RANGE >= (2 ** (Z_W - Z_FRAC - 1))) begin : g_bad_range
      $error("range does not fit the input integer field");
   end
   if (F + GUARD + 5 > 31) begin : g_bad_width
      $error("table precision exceeds the builder");
   end

   logic [AW-1:0]      idx;
   logic [AW-1:0]      idx_next;
   logic [ZL_W-1:0]    zl;
   logic               over;
   logic [1:0][AW-1:0] rom_addr;
   logic [1:0][TW-1:0] rom_data;
   logic [ZL_W-1:0]    zl_q;
   logic               over_q;
   logic               vld_q;

   lns_sb_decode #(
      .Z_W(Z_W), .Z_FRAC(Z_FRAC), .N(N), .RANGE(RANGE), .E(E), .AW(AW)
   ) u_decode (
      .z(in_z), .idx(idx), .idx_next(idx_next), .zl(zl), .over(over)
   );

   assign rom_addr[0] = idx;
   assign rom_addr[1] = idx_next;

   lns_sb_rom #(
      .E(E), .AW(AW), .TW(TW), .N(N), .TFRAC(F + GUARD)
   ) u_rom (
      .clk(clk), .rst(rst), .en(in_valid & ~over),
      .addr(rom_addr), .data(rom_data)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         zl_q   <= '0;
         over_q <= 1'b0;
         vld_q  <= 1'b0;
      end else begin
         zl_q   <= zl;
         over_q <= over;
         vld_q  <= in_valid;
      end
   end

   lns_sb_interp #(
      .TW(TW), .ZL_W(ZL_W), .G(GUARD), .F(F)
   ) u_interp (
      .clk(clk), .rst(rst), .vld_i(vld_q), .over_i(over_q),
      .base_i(rom_data[0]), .next_i(rom_data[1]), .zl_i(zl_q),
      .vld_o(out_valid), .sb_o(out_sb)
   );

endmodule

// File: rtl/lns_sb_unit_chk.sv
module lns_sb_unit_chk #(
   parameter int Z_W    = 20,
   parameter int Z_FRAC = 12,
   parameter int F      = 12,
   parameter int RANGE  = 12
) (
   input logic           clk,
   input logic           rst,
   input logic           in_valid,
   input logic [Z_W-1:0] in_z,
   input logic           out_valid,
   input logic [F:0]     out_sb
);
   localparam logic [Z_W-1:0] LIMIT = Z_W'(RANGE) << Z_FRAC;
   localparam logic [F:0]     ONE   = (F+1)'(1) << F;

   logic [Z_W-1:0] mag;
   logic [2:0]     v_sh;
   logic [2:0]     pos_sh;
   logic [2:0]     over_sh;
   logic [2:0]     inr_sh;

   assign mag = in_z[Z_W-1] ? (~in_z + 1'b1) : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         v_sh    <= '0;
         pos_sh  <= '0;
         over_sh <= '0;
         inr_sh  <= '0;
      end else begin
         v_sh    <= {v_sh[1:0],    in_valid};
         pos_sh  <= {pos_sh[1:0],  in_valid & ~in_z[Z_W-1]};
         over_sh <= {over_sh[1:0], in_valid & (mag > LIMIT)};
         inr_sh  <= {inr_sh[1:0],  in_valid & in_z[Z_W-1] & (mag <= LIMIT)};
      end
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
      out_valid == v_sh[2]);                                            // R2
   AST_POSITIVE_ONE: assert property (@(posedge clk) disable iff (rst)
      (out_valid && pos_sh[2]) |-> (out_sb == ONE));                    // R3
   AST_OVER_ZERO: assert property (@(posedge clk) disable iff (rst)
      (out_valid && over_sh[2]) |-> (out_sb == '0));                    // R4
   AST_IN_RANGE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
      (out_valid && inr_sh[2]) |-> (out_sb != '0 && out_sb <= ONE));    // R1
   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (!out_valid && out_sb == '0));                            // R7

endmodule

bind lns_sb_unit lns_sb_unit_chk #(
   .Z_W(Z_W), .Z_FRAC(Z_FRAC), .F(F), .RANGE(RANGE)
) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_z(in_z),
   .out_valid(out_valid), .out_sb(out_sb)
);

// File: tb/lns_sb_unit_test.sv
`timescale 1ns/1ps
module lns_sb_unit_test;
   localparam int LIMIT = 12 * 4096;
   localparam int ONE   = 4096;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               in_valid = 1'b0;
   logic signed [19:0] in_z = '0;
   logic               out_valid;
   logic [12:0]        out_sb;

   int checks = 0;
   int errors = 0;

   logic               hv [0:2];
   logic signed [19:0] hz [0:2];
   bit                 have_prev = 0;
   int                 prev_mag = 0;
   int                 prev_out = 0;

   always #2.5 clk = ~clk;

   lns_sb_unit uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_z(in_z),
      .out_valid(out_valid), .out_sb(out_sb)
   );

   task automatic check_slot(input logic v, input logic signed [19:0] z);
      int  zi;
      int  o;
      real r;
      real d;
      zi = int'(z);
      o  = int'(out_sb);
      checks++;
      if (out_valid !== v) begin
         errors++;
         $display("FAIL R2/R8 out_valid=%0b expected %0b (z=%0d)", out_valid, v, zi);
      end
      if (v) begin
         checks++;
         if (zi >= 0) begin
            if (o != ONE) begin
               errors++;
               $display("FAIL R3 z=%0d out=%0d expected %0d", zi, o, ONE);
            end
            have_prev = 0;
         end else if (-zi > LIMIT) begin
            if (o != 0) begin
               errors++;
               $display("FAIL R4 z=%0d out=%0d expected 0", zi, o);
            end
            have_prev = 0;
         end else begin
            r = ($ln(1.0 + $pow(2.0, real'(zi) / 4096.0)) / $ln(2.0)) * 4096.0;
            d = real'(o) - r;
            if (d > 1.0 || d < -1.0 || o > ONE) begin
               errors++;
               $display("FAIL R1 z=%0d out=%0d expected %f", zi, o, r);
            end
            if (-zi == LIMIT) begin
               checks++;
               if (o == 0) begin
                  errors++;
                  $display("FAIL R5 z=%0d out=%0d expected %f", zi, o, r);
               end
            end
            if (have_prev && (-zi == prev_mag + 1)) begin
               checks++;
               if (o > prev_out) begin
                  errors++;
                  $display("FAIL R6 z=%0d out=%0d expected <= %0d", zi, o, prev_out);
               end
            end
            have_prev = 1;
            prev_mag  = -zi;
            prev_out  = o;
         end
      end
   endtask

   task automatic step(input logic v, input logic signed [19:0] z);
      @(negedge clk);
      check_slot(hv[2], hz[2]);
      hv[2] = hv[1]; hz[2] = hz[1];
      hv[1] = hv[0]; hz[1] = hz[0];
      hv[0] = v;     hz[0] = z;
      in_valid = v;
      in_z     = z;
   endtask

   initial begin
      #(5.0 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 3; i++) begin
         hv[i] = 1'b0;
         hz[i] = '0;
      end
      repeat (4) @(negedge clk);
      // R7: cleared state during reset
      checks++;
      if (out_valid !== 1'b0 || out_sb !== '0) begin
         errors++;
         $display("FAIL R7 out_valid=%0b out=%0d expected 0 0", out_valid, out_sb);
      end
      rst = 1'b0;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_sb !== '0) begin
         errors++;
         $display("FAIL R7 after reset out_valid=%0b out=%0d expected 0 0", out_valid, out_sb);
      end
      // R3: non-negative arguments
      step(1'b1, 20'sd0);
      step(1'b1, 20'sd1);
      step(1'b1, 20'sd4096);
      step(1'b1, 20'sd524287);
      // R1 R5 R6 R8: every in-range code back to back, then past the limit
      for (int m = 0; m <= LIMIT + 64; m++) step(1'b1, 20'(-m));
      // R4: extreme negative codes
      step(1'b1, -20'sd524288);
      step(1'b1, -20'sd300000);
      step(1'b1, -20'sd49153);
      // R2: gapped traffic
      for (int i = 0; i < 40; i++) begin
         step(1'b0, 20'(-(i * 977)));
         step(1'b1, 20'(-(i * 1291)));
         step(i[0], 20'(-(i * 1601)));
      end
      for (int i = 0; i < 4; i++) step(1'b0, '0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule